// File: doc/BRIEF.md
# Coherent TLB Invalidation Snooper

This unit sits next to a core's unified translation buffer and its small shadow translation buffers. It keeps the cross-core view of translations consistent. When local software rewrites the high word of a unified entry with the valid flag cleared, the unit drops that entry and emits a one-cycle outgoing invalidate message. The message carries the virtual tag, so that peer cores can act on it.

When a peer's invalidate message arrives, the unit queues it and then sweeps the whole unified buffer. The sweep covers a bank of `LANES` entries per cycle. It clears every valid entry whose tag equals the received virtual tag. The process ID stored with an entry plays no part in this match, so translations that belong to other processes can be dropped too. Any later access to a dropped entry takes the ordinary miss path. On its first cycle the sweep also pulses a flush strobe that empties the shadow buffers completely. Local lookups are stalled from the moment an invalidation is pending until its sweep ends, so a stale translation can never hit.

The unit keeps its own copy of each entry's valid bit, virtual tag and process ID. This copy is written through the same high-word write port that the unified buffer uses. Lookups and sweeps are resolved against this copy, and every clear is also reported on the per-bank clear strobes.

Top module: `tlb_inval_snoop`

## Requirements
- R1: A cycle with `wr_en`=1 and `wr_valid`=0 raises `bcast_valid` for exactly the following cycle, with `bcast_tag` equal to that cycle's `wr_tag`.
- R2: Nothing else raises `bcast_valid`: not writes with `wr_valid`=1, not received peer invalidations, and not idle cycles. Changing a page only in memory, without a write on this port, therefore sends nothing.
- R3: An accepted peer invalidation clears every valid entry whose stored tag equals `peer_tag`, whatever process ID that entry holds, and leaves every other entry untouched. Each sweep cycle reports its cleared entries on `utlb_clr_mask`, where bit i names entry `utlb_clr_bank`*LANES+i.
- R4: `shadow_flush` pulses for one cycle per accepted peer invalidation, in that invalidation's first sweep cycle (bank 0). It pulses even when no unified entry matches.
- R5: A sweep raises `utlb_clr_valid` for ENTRIES/LANES consecutive cycles, with banks 0, 1, 2, … in order. `busy` rises in the cycle after a peer invalidation is accepted. For an isolated invalidation, `busy` stays high for ENTRIES/LANES+1 cycles (9 at the defaults).
- R6: When the unit is not busy, a lookup hits only on a valid entry whose tag and process ID both match. `lkp_idx` gives the lowest such entry index.
- R7: While `busy` is high, a lookup request gives `lkp_stall`=1 and `lkp_hit`=0. While `busy` is low, `lkp_stall` is 0.
- R8: After a sweep, a lookup of a cleared entry with its original process ID misses. Entries whose tag differed still hit.
- R9: Up to PEND_DEPTH (2) accepted invalidations wait while one sweeps, and they are swept in arrival order. `peer_ready` is low whenever PEND_DEPTH invalidations are waiting, and the sender keeps `peer_valid` low while `peer_ready` is low.
- R10: A local write with `wr_valid`=0 also invalidates the written entry itself, so a later lookup of it misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | High-word write strobe |
| wr_idx | input | IDX_W (6) | Entry being written |
| wr_tag | input | TAG_W (20) | Virtual tag written |
| wr_tid | input | TID_W (8) | Process ID written |
| wr_valid | input | 1 | Valid flag written; 0 triggers a broadcast |
| bcast_valid | output | 1 | Outgoing invalidate message strobe |
| bcast_tag | output | TAG_W | Tag carried by the outgoing message |
| peer_valid | input | 1 | Incoming peer invalidate strobe |
| peer_tag | input | TAG_W | Tag of the incoming invalidate |
| peer_ready | output | 1 | Pending queue can accept a peer invalidate |
| lkp_req | input | 1 | Local lookup request |
| lkp_tag | input | TAG_W | Lookup virtual tag |
| lkp_tid | input | TID_W | Lookup process ID |
| lkp_hit | output | 1 | Lookup found a matching entry |
| lkp_idx | output | IDX_W | Lowest matching entry |
| lkp_stall | output | 1 | Lookup held off by a pending sweep |
| utlb_clr_valid | output | 1 | Sweep cycle; clear strobes are meaningful |
| utlb_clr_bank | output | BANK_W (3) | Bank swept this cycle |
| utlb_clr_mask | output | LANES (8) | Entries of the bank cleared this cycle |
| shadow_flush | output | 1 | Empty all shadow entries |
| busy | output | 1 | Invalidation pending or sweeping |

## Verification
The sweep is tried against a tag held by five entries in four banks, with different process IDs, including two entries in the same bank. This separates a true all-match sweep from one that stops at the first hit or honours the process ID. An invalidation whose tag matches nothing checks that the shadow flush and the full bank walk still happen with zero masks. A burst of four back-to-back invalidations, each with tags in different entries, shows queue ordering: any reordering would put a mask on the wrong sweep. Local writes with the valid flag set and with it clear, mixed with peer traffic, tell the real broadcast trigger apart from look-alikes.

// File: rtl/tlbsn_pkg.sv
package tlbsn_pkg;

   // Sweep engine phase
   typedef enum logic [0:0] {
      SW_IDLE = 1'b0,
      SW_RUN  = 1'b1
   } sweep_state_e;

endpackage

// File: rtl/tlbsn_fifo.sv
// Pending-invalidate queue; a depth of one selects a plain holding register.
module tlbsn_fifo #(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned W     = 20,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] hold_q;
         logic         held_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               held_q <= 1'b0;
               hold_q <= '0;
            end else begin
               if (push && !held_q) begin
                  held_q <= 1'b1;
                  hold_q <= din;
               end else if (pop && held_q) begin
                  held_q <= 1'b0;
               end
            end
         end

         assign dout  = hold_q;
         assign full  = held_q;
         assign empty = !held_q;
      end else begin : g_ring
         localparam int unsigned PTR_W = $clog2(DEPTH);
         localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

         logic [W-1:0]     slot_q [DEPTH];
         logic [PTR_W-1:0] rd_p_q, wr_p_q;
         logic [CNT_W-1:0] cnt_q;
         logic             do_push, do_pop;

         assign full    = (cnt_q == CNT_W'(DEPTH));
         assign empty   = (cnt_q == '0);
         assign do_push = push && !full;
         assign do_pop  = pop && !empty;
         assign dout    = slot_q[rd_p_q];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_p_q <= '0;
               wr_p_q <= '0;
               cnt_q  <= '0;
            end else begin
               if (do_push) wr_p_q <= (wr_p_q == PTR_LAST) ? '0 : wr_p_q + PTR_W'(1);
               if (do_pop)  rd_p_q <= (rd_p_q == PTR_LAST) ? '0 : rd_p_q + PTR_W'(1);
               case ({do_push, do_pop})
                  2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                  2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                  default: cnt_q <= cnt_q;
               endcase
            end
         end

         always_ff @(posedge clk) begin
            if (do_push) slot_q[wr_p_q] <= din;
         end
      end
   endgenerate

endmodule

// File: rtl/tlbsn_entry_store.sv
// Copy of the unified buffer's high words: valid, tag and process ID per entry.
module tlbsn_entry_store #(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned LANES   = 8,
   parameter int unsigned TAG_W   = 20,
   parameter int unsigned TID_W   = 8,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned LANE_W = $clog2(LANES),
   localparam int unsigned BANK_W = IDX_W - LANE_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [IDX_W-1:0]             wr_idx,
   input  logic [TAG_W-1:0]             wr_tag,
   input  logic [TID_W-1:0]             wr_tid,
   input  logic                         wr_valid,
   input  logic                         clr_en,
   input  logic [BANK_W-1:0]            clr_bank,
   input  logic [LANES-1:0]             clr_mask,
   input  logic [BANK_W-1:0]            rd_bank,
   output logic [LANES-1:0][TAG_W-1:0]  rd_tag,
   output logic [LANES-1:0]             rd_vld,
   input  logic [TAG_W-1:0]             lkp_tag,
   input  logic [TID_W-1:0]             lkp_tid,
   output logic                         lkp_any,
   output logic [IDX_W-1:0]             lkp_idx
);

   logic [ENTRIES-1:0] vld_q, vld_nxt;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [TID_W-1:0]   tid_q [ENTRIES];

   // Per-entry next valid bit: a local write wins over a sweep clear.
   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
         localparam logic [BANK_W-1:0] E_BANK = BANK_W'(e / LANES);
         localparam logic [LANE_W-1:0] E_LANE = LANE_W'(e % LANES);
         logic wr_hit, clr_hit;

         assign wr_hit      = wr_en && (wr_idx == IDX_W'(e));
         assign clr_hit     = clr_en && (clr_bank == E_BANK) && clr_mask[E_LANE];
         assign vld_nxt[e]  = wr_hit ? wr_valid : (clr_hit ? 1'b0 : vld_q[e]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= vld_nxt;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         tid_q[wr_idx] <= wr_tid;
      end
   end

   // Bank read port feeding the sweep comparators.
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_rd
         localparam logic [LANE_W-1:0] L_SEL = LANE_W'(l);
         assign rd_tag[l] = tag_q[{rd_bank, L_SEL}];
         assign rd_vld[l] = vld_q[{rd_bank, L_SEL}];
      end
   endgenerate

   // Full associative lookup, lowest index wins.
   always_comb begin
      lkp_any = 1'b0;
      lkp_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (vld_q[e] && (tag_q[e] == lkp_tag) && (tid_q[e] == lkp_tid)) begin
            lkp_any = 1'b1;
            lkp_idx = IDX_W'(e);
         end
      end
   end

endmodule

// File: rtl/tlbsn_lane_match.sv
// One comparator per lane; process ID deliberately not compared.
module tlbsn_lane_match #(
   parameter int unsigned LANES = 8,
   parameter int unsigned TAG_W = 20
) (
   input  logic [LANES-1:0][TAG_W-1:0] rd_tag,
   input  logic [LANES-1:0]            rd_vld,
   input  logic [TAG_W-1:0]            cmp_tag,
   input  logic                        cmp_en,
   output logic [LANES-1:0]            hit_mask
);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign hit_mask[l] = cmp_en && rd_vld[l] && (rd_tag[l] == cmp_tag);
      end
   endgenerate

endmodule

// File: rtl/tlbsn_sweep_ctl.sv
// Walks all banks once per invalidation, taking the next one without a gap.
module tlbsn_sweep_ctl #(
   parameter int unsigned TAG_W = 20,
   parameter int unsigned BANKS = 8,
   localparam int unsigned BANK_W = $clog2(BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_empty,
   input  logic [TAG_W-1:0]  q_tag,
   output logic              q_pop,
   output logic              running,
   output logic              first,
   output logic [BANK_W-1:0] bank,
   output logic [TAG_W-1:0]  cur_tag
);
   import tlbsn_pkg::*;

   localparam logic [BANK_W-1:0] BANK_LAST = BANK_W'(BANKS - 1);

   sweep_state_e      st_q;
   logic [BANK_W-1:0] bank_q;
   logic [TAG_W-1:0]  tag_q;
   logic              at_last;

   assign at_last = (bank_q == BANK_LAST);
   assign q_pop   = !q_empty && ((st_q == SW_IDLE) || at_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SW_IDLE;
         bank_q <= '0;
         tag_q  <= '0;
      end else if (q_pop) begin
         st_q   <= SW_RUN;
         bank_q <= '0;
         tag_q  <= q_tag;
      end else if (st_q == SW_RUN) begin
         if (at_last) begin
            st_q   <= SW_IDLE;
            bank_q <= '0;
         end else begin
            bank_q <= bank_q + BANK_W'(1);
         end
      end
   end

   assign running = (st_q == SW_RUN);
   assign first   = running && (bank_q == '0);
   assign bank    = bank_q;
   assign cur_tag = tag_q;

endmodule

// File: rtl/tlb_inval_snoop.sv
module tlb_inval_snoop #(
   parameter int unsigned ENTRIES    = 64,
   parameter int unsigned LANES      = 8,
   parameter int unsigned TAG_W      = 20,
   parameter int unsigned TID_W      = 8,
   parameter int unsigned PEND_DEPTH = 2,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned LANE_W = $clog2(LANES),
   localparam int unsigned BANK_W = IDX_W - LANE_W,
   localparam int unsigned BANKS  = ENTRIES / LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [TID_W-1:0]  wr_tid,
   input  logic              wr_valid,
   output logic              bcast_valid,
   output logic [TAG_W-1:0]  bcast_tag,
   input  logic              peer_valid,
   input  logic [TAG_W-1:0]  peer_tag,
   output logic              peer_ready,
   input  logic              lkp_req,
   input  logic [TAG_W-1:0]  lkp_tag,
   input  logic [TID_W-1:0]  lkp_tid,
   output logic              lkp_hit,
   output logic [IDX_W-1:0]  lkp_idx,
   output logic              lkp_stall,
   output logic              utlb_clr_valid,
   output logic [BANK_W-1:0] utlb_clr_bank,
   output logic [LANES-1:0]  utlb_clr_mask,
   output logic              shadow_flush,
   output logic              busy
);

   // Elaboration-time parameter checks
   generate
      if (ENTRIES != (1 << IDX_W)) begin : g_bad_entries
         $error("ENTRIES must be a power of two");
      end
      if ((LANES < 2) || (LANES != (1 << LANE_W))) begin : g_bad_lanes
         $error("LANES must be a power of two, at least 2");
      end
      if (BANKS < 2) begin : g_bad_banks
         $error("ENTRIES must be at least twice LANES");
      end
      if ((PEND_DEPTH < 1) || (TAG_W < 1) || (TID_W < 1)) begin : g_bad_sizes
         $error("PEND_DEPTH, TAG_W and TID_W must be non-zero");
      end
   endgenerate

   logic                        q_full, q_empty, q_pop;
   logic [TAG_W-1:0]            q_tag;
   logic                        sw_run, sw_first;
   logic [BANK_W-1:0]           sw_bank;
   logic [TAG_W-1:0]            sw_tag;
   logic [LANES-1:0][TAG_W-1:0] bank_tags;
   logic [LANES-1:0]            bank_vld;
   logic [LANES-1:0]            hit_mask;
   logic                        lk_any;
   logic [IDX_W-1:0]            lk_idx;
   logic                        bc_v_q;
   logic [TAG_W-1:0]            bc_tag_q;

   // Outgoing message: a high-word write that clears the valid flag.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bc_v_q   <= 1'b0;
         bc_tag_q <= '0;
      end else begin
         bc_v_q <= wr_en && !wr_valid;
         if (wr_en && !wr_valid) bc_tag_q <= wr_tag;
      end
   end

   assign bcast_valid = bc_v_q;
   assign bcast_tag   = bc_tag_q;

   tlbsn_fifo #(
      .DEPTH (PEND_DEPTH),
      .W     (TAG_W)
   ) pend_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (peer_valid),
      .din   (peer_tag),
      .pop   (q_pop),
      .dout  (q_tag),
      .full  (q_full),
      .empty (q_empty)
   );

   tlbsn_sweep_ctl #(
      .TAG_W (TAG_W),
      .BANKS (BANKS)
   ) sweep_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .q_empty (q_empty),
      .q_tag   (q_tag),
      .q_pop   (q_pop),
      .running (sw_run),
      .first   (sw_first),
      .bank    (sw_bank),
      .cur_tag (sw_tag)
   );

   tlbsn_entry_store #(
      .ENTRIES (ENTRIES),
      .LANES   (LANES),
      .TAG_W   (TAG_W),
      .TID_W   (TID_W)
   ) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_tag   (wr_tag),
      .wr_tid   (wr_tid),
      .wr_valid (wr_valid),
      .clr_en   (sw_run),
      .clr_bank (sw_bank),
      .clr_mask (hit_mask),
      .rd_bank  (sw_bank),
      .rd_tag   (bank_tags),
      .rd_vld   (bank_vld),
      .lkp_tag  (lkp_tag),
      .lkp_tid  (lkp_tid),
      .lkp_any  (lk_any),
      .lkp_idx  (lk_idx)
   );

   tlbsn_lane_match #(
      .LANES (LANES),
      .TAG_W (TAG_W)
   ) match_i (
      .rd_tag   (bank_tags),
      .rd_vld   (bank_vld),
      .cmp_tag  (sw_tag),
      .cmp_en   (sw_run),
      .hit_mask (hit_mask)
   );

   assign busy           = sw_run || !q_empty;
   assign peer_ready     = !q_full;
   assign utlb_clr_valid = sw_run;
   assign utlb_clr_bank  = sw_bank;
   assign utlb_clr_mask  = hit_mask;
   assign shadow_flush   = sw_first;
   assign lkp_stall      = lkp_req && busy;
   assign lkp_hit        = lkp_req && !busy && lk_any;
   assign lkp_idx        = lk_idx;

endmodule

// File: rtl/tlbsn_checker.sv
module tlbsn_checker #(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned LANES   = 8,
   parameter int unsigned TAG_W   = 20,
   localparam int unsigned BANKS  = ENTRIES / LANES,
   localparam int unsigned BANK_W = $clog2(BANKS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_valid,
   input logic [TAG_W-1:0]  wr_tag,
   input logic              bcast_valid,
   input logic [TAG_W-1:0]  bcast_tag,
   input logic              peer_valid,
   input logic              peer_ready,
   input logic              lkp_req,
   input logic              lkp_hit,
   input logic              lkp_stall,
   input logic              busy,
   input logic              utlb_clr_valid,
   input logic [BANK_W-1:0] utlb_clr_bank,
   input logic              shadow_flush
);

   localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(BANKS - 1);

   p_bcast_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_valid) |=> (bcast_valid && (bcast_tag == $past(wr_tag))));

   p_bcast_only_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && !wr_valid) |=> !bcast_valid);

   p_flush_first_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      shadow_flush |-> (utlb_clr_valid && (utlb_clr_bank == '0)));

   p_sweep_starts_bank0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(utlb_clr_valid) |-> (utlb_clr_bank == '0));

   p_bank_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (utlb_clr_valid && (utlb_clr_bank != LAST_BANK)) |=>
      (utlb_clr_valid && (utlb_clr_bank == $past(utlb_clr_bank) + BANK_W'(1))));

   p_clear_inside_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      utlb_clr_valid |-> busy);

   p_stall_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lkp_req && busy) |-> (lkp_stall && !lkp_hit));

   p_no_stall_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !lkp_stall);

   p_sender_honours_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      peer_valid |-> peer_ready);

endmodule

bind tlb_inval_snoop tlbsn_checker #(
   .ENTRIES (ENTRIES),
   .LANES   (LANES),
   .TAG_W   (TAG_W)
) chk_i (.*);

// File: tb/tlb_inval_snoop_tb_top.sv
module tlb_inval_snoop_tb_top;

   localparam int ENTRIES = 64;
   localparam int LANES   = 8;
   localparam int TAG_W   = 20;
   localparam int TID_W   = 8;
   localparam int BANKS   = ENTRIES / LANES;

   localparam logic [TAG_W-1:0] TG_A = 20'h0AAAA;
   localparam logic [TAG_W-1:0] TG_B = 20'h0BBBB;
   localparam logic [TAG_W-1:0] TG_C = 20'h0C0C0;
   localparam logic [TAG_W-1:0] TG_D = 20'h0D0D0;
   localparam logic [TAG_W-1:0] TG_E = 20'h0E0E0;
   localparam logic [TAG_W-1:0] TG_N = 20'h01234;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [5:0]       wr_idx = '0;
   logic [TAG_W-1:0] wr_tag = '0;
   logic [TID_W-1:0] wr_tid = '0;
   logic             wr_valid = 1'b0;
   logic             bcast_valid;
   logic [TAG_W-1:0] bcast_tag;
   logic             peer_valid = 1'b0;
   logic [TAG_W-1:0] peer_tag = '0;
   logic             peer_ready;
   logic             lkp_req = 1'b0;
   logic [TAG_W-1:0] lkp_tag = '0;
   logic [TID_W-1:0] lkp_tid = '0;
   logic             lkp_hit;
   logic [5:0]       lkp_idx;
   logic             lkp_stall;
   logic             utlb_clr_valid;
   logic [2:0]       utlb_clr_bank;
   logic [LANES-1:0] utlb_clr_mask;
   logic             shadow_flush;
   logic             busy;

   always #5 clk = ~clk;

   tlb_inval_snoop dut_i (.*);

   // Reference model of entry contents
   bit               m_vld [ENTRIES];
   logic [TAG_W-1:0] m_tag [ENTRIES];
   logic [TID_W-1:0] m_tid [ENTRIES];

   typedef struct {
      logic [TAG_W-1:0] tag;
      longint           cyc;
   } bc_item_t;

   bc_item_t         bc_q [$];
   logic [TAG_W-1:0] sw_q [$];

   int     n_cmp = 0;
   int     n_bad = 0;
   int     n_flush = 0;
   int     n_peer = 0;
   int     n_stray_bc = 0;
   longint cyc = 0;
   bit     done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr_op(input int idx, input logic [TAG_W-1:0] t,
                        input logic [TID_W-1:0] id, input bit v);
      bc_item_t it;
      @(posedge clk); #2;
      wr_en = 1'b1; wr_idx = 6'(idx); wr_tag = t; wr_tid = id; wr_valid = v;
      m_vld[idx] = v; m_tag[idx] = t; m_tid[idx] = id;
      if (!v) begin
         it.tag = t; it.cyc = cyc + 1;
         bc_q.push_back(it);
      end
   endtask

   task automatic wr_idle();
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic peer_send(input logic [TAG_W-1:0] t);
      @(posedge clk); #2;
      while (!peer_ready) begin
         peer_valid = 1'b0;
         @(posedge clk); #2;
      end
      peer_valid = 1'b1; peer_tag = t;
      sw_q.push_back(t);
      n_peer++;
   endtask

   task automatic peer_idle();
      @(posedge clk); #2;
      peer_valid = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (!busy) break;
      end
   endtask

   // Lookup compared against the model (unit idle)
   task automatic lk(input logic [TAG_W-1:0] t, input logic [TID_W-1:0] id,
                     input string req);
      bit       eh;
      int       ei;
      eh = 1'b0; ei = 0;
      @(posedge clk); #2;
      lkp_req = 1'b1; lkp_tag = t; lkp_tid = id;
      for (int e = ENTRIES - 1; e >= 0; e--)
         if (m_vld[e] && m_tag[e] == t && m_tid[e] == id) begin eh = 1'b1; ei = e; end
      @(negedge clk);
      chk(lkp_hit == eh, req, "lookup hit", lkp_hit, eh);
      if (eh) chk(lkp_idx == 6'(ei), req, "lookup index", lkp_idx, ei);
      chk(lkp_stall == 1'b0, req, "idle stall", lkp_stall, 0);
   endtask

   // Monitor: pops expected broadcasts and sweeps as they appear
   logic [TAG_W-1:0] mon_tag;
   int               mon_bank;
   logic [LANES-1:0] exp_mask;
   int               ent;
   bc_item_t         got;

   always @(negedge clk) begin
      if (rst_n) begin
         if (bcast_valid) begin
            if (bc_q.size() == 0) begin
               n_stray_bc++;
               chk(1'b0, "R2", "stray broadcast", bcast_tag, 0);
            end else begin
               got = bc_q.pop_front();
               chk(bcast_tag == got.tag, "R1", "broadcast tag", bcast_tag, got.tag);
               chk(cyc == got.cyc, "R1", "broadcast cycle", cyc, got.cyc);
            end
         end
         if (utlb_clr_valid) begin
            if (shadow_flush) begin
               n_flush++;
               mon_bank = 0;
               if (sw_q.size() == 0) chk(1'b0, "R4", "flush without invalidate", 1, 0);
               else mon_tag = sw_q.pop_front();
            end
            chk(int'(utlb_clr_bank) == mon_bank, "R5", "sweep bank order",
                utlb_clr_bank, mon_bank);
            exp_mask = '0;
            for (int l = 0; l < LANES; l++) begin
               ent = mon_bank * LANES + l;
               if (m_vld[ent] && m_tag[ent] == mon_tag) exp_mask[l] = 1'b1;
            end
            chk(utlb_clr_mask == exp_mask, "R3", "clear mask", utlb_clr_mask, exp_mask);
            for (int l = 0; l < LANES; l++)
               if (exp_mask[l]) m_vld[mon_bank * LANES + l] = 1'b0;
            mon_bank++;
         end else if (shadow_flush) begin
            chk(1'b0, "R4", "flush outside sweep", 1, 0);
         end
      end
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R5 watchdog: actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int nb;
      int bad_stall;
      for (int e = 0; e < ENTRIES; e++) m_vld[e] = 1'b0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R5", "reset busy", busy, 0);
      chk(bcast_valid == 1'b0, "R2", "reset broadcast", bcast_valid, 0);
      chk(peer_ready == 1'b1, "R9", "reset ready", peer_ready, 1);
      chk(utlb_clr_valid == 1'b0 && shadow_flush == 1'b0, "R4", "reset strobes",
          {utlb_clr_valid, shadow_flush}, 0);

      // Fill: defaults, then one tag in several entries with mixed process IDs
      for (int e = 0; e < ENTRIES; e++) wr_op(e, TAG_W'(20'h100 + e), TID_W'(e), 1'b1);
      wr_op(3,  TG_A, 8'd1, 1'b1);
      wr_op(12, TG_A, 8'd2, 1'b1);
      wr_op(13, TG_A, 8'd3, 1'b1);
      wr_op(40, TG_A, 8'd1, 1'b1);
      wr_op(63, TG_A, 8'd9, 1'b1);
      wr_op(5,  TG_B, 8'd1, 1'b1);
      wr_idle();
      repeat (2) @(negedge clk);
      chk(n_stray_bc == 0, "R2", "no broadcast for valid writes", n_stray_bc, 0);

      // R6: lookups need tag and process ID, lowest index wins
      lk(TG_A, 8'd2, "R6");
      lk(TG_A, 8'd1, "R6");
      lk(TG_A, 8'd7, "R6");
      lk(TG_B, 8'd1, "R6");
      lk(TAG_W'(20'h100 + 20), 8'd20, "R6");

      // Peer invalidation of A, lookup held during the window
      peer_send(TG_A);
      @(posedge clk); #2;
      peer_valid = 1'b0;
      lkp_req = 1'b1; lkp_tag = TG_A; lkp_tid = 8'd2;
      nb = 0; bad_stall = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (!busy) break;
         nb++;
         if (!lkp_stall || lkp_hit) bad_stall++;
      end
      chk(nb == BANKS + 1, "R5", "busy length", nb, BANKS + 1);
      chk(bad_stall == 0, "R7", "stall during sweep", bad_stall, 0);
      chk(lkp_hit == 1'b0 && lkp_stall == 1'b0, "R8", "cleared entry after sweep",
          {lkp_hit, lkp_stall}, 0);
      chk(n_flush == 1, "R4", "flush count", n_flush, 1);
      chk(n_stray_bc == 0, "R2", "no broadcast on peer invalidate", n_stray_bc, 0);
      lk(TG_A, 8'd1, "R8");
      lk(TG_A, 8'd9, "R8");
      lk(TG_B, 8'd1, "R8");
      lk(TAG_W'(20'h100 + 21), 8'd21, "R8");

      // Local invalidation of B
      wr_op(5, TG_B, 8'd1, 1'b0);
      wr_idle();
      lk(TG_B, 8'd1, "R10");

      // Invalidation matching nothing still flushes the shadows
      peer_send(TG_N);
      peer_idle();
      wait_idle();
      chk(n_flush == 2, "R4", "flush with no match", n_flush, 2);

      // Burst of four: order and back-pressure
      wr_op(1,  TG_C, 8'd4, 1'b1);
      wr_op(9,  TG_C, 8'd5, 1'b1);
      wr_op(2,  TG_D, 8'd4, 1'b1);
      wr_op(50, TG_E, 8'd4, 1'b1);
      wr_idle();
      peer_send(TG_C);
      peer_send(TG_D);
      peer_send(TG_E);
      @(posedge clk); #2;
      peer_valid = 1'b0;
      chk(peer_ready == 1'b0, "R9", "ready low with two waiting", peer_ready, 0);
      peer_send(TG_C);
      peer_idle();
      wait_idle();
      chk(n_flush == n_peer, "R9", "all queued invalidations swept", n_flush, n_peer);
      chk(sw_q.size() == 0, "R9", "sweep queue drained", sw_q.size(), 0);
      lk(TG_C, 8'd5, "R8");
      lk(TG_D, 8'd4, "R8");
      lk(TG_E, 8'd4, "R8");

      // Local invalidation right after a peer one
      wr_op(30, TAG_W'(20'h100 + 30), 8'd30, 1'b0);
      wr_idle();
      repeat (3) @(negedge clk);
      chk(bc_q.size() == 0, "R1", "all broadcasts seen", bc_q.size(), 0);
      chk(n_stray_bc == 0, "R2", "no stray broadcast overall", n_stray_bc, 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule